// File: doc/BRIEF.md
# Ternary Trit Logic Unit

This unit applies one three-valued logic operation, digit by digit, across a vector of balanced-ternary digits (trits). Every trit uses a pair of wires, one flag for the positive value and one for the negative value. An operation code picks the function. Some functions take one operand: three match tests against a fixed value, increment and decrement. The others take two: equality, modulo-3 sum, consensus, accept-anything, inverted minimum and inverted maximum. No carry passes between trit positions. Each position is computed on its own.

The result vector and an error flag are registered. Both appear one clock after the operands and operation code are sampled. The error flag marks an operand trit with an illegal encoding, or an operation code that is not defined. The unit fits into a larger datapath wherever trit-wise ternary logic is needed.

Top module: `ttl_unit`

## Requirements
- R1: A trit is encoded as 2'b01 = +, 2'b10 = −, 2'b00 = 0, with bit 0 the plus flag and bit 1 the minus flag. Trit k of a vector occupies bits [2k+1:2k]. Outputs are registered with one clock of latency. While reset (active low) is asserted, and right after it, the result is all zeros and the error flag is 0.
- R2: Op codes 0, 1 and 2 test whether operand A is −, 0 or + respectively. Each trit of the result is + on a match and − otherwise.
- R3: Op 5 (equality) gives + where the A and B trits are equal and − where they differ.
- R4: Op 3 (increment) maps − to 0, 0 to + and + to −.
- R5: Op 4 (decrement) maps + to 0, 0 to − and − to +.
- R6: Op 6 (modulo-3 sum) gives −,− → +; −,0 → −; −,+ → 0; 0,x → x; +,− → 0; +,0 → +; +,+ → −.
- R7: Op 7 (consensus) gives the shared value where A equals B, and 0 everywhere else.
- R8: Op 8 (accept-anything) gives 0 where both trits are 0 or where one trit is + and the other is −. Otherwise it gives the non-zero value that is present.
- R9: Op 9 gives the negation of min(A,B) and op 10 gives the negation of max(A,B), with the order − < 0 < +. Negation swaps + and −.
- R10: If any trit of A or B is 2'b11, the error flag is 1 for that result. The illegal trit is treated as 0 in the computation, and no result trit is ever 2'b11.
- R11: Op codes 11 to 15 are illegal. They give an all-zero result with the error flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| a_i | input | 2*N_TRITS | Operand A trit vector |
| b_i | input | 2*N_TRITS | Operand B trit vector (used by two-input operations) |
| res_o | output | 2*N_TRITS | Registered result trit vector |
| err_o | output | 1 | Registered error flag (illegal trit or illegal op code) |

## Verification
The only state in the unit is the output register, so any fault shows up at the ports one clock after the stimulus that exposes it. A wrong mapping in a trit cell produces a wrong trit in that position. A fault in the legality check shows up as a missing or a spurious error flag. Operand vectors rotate the trit values across positions, so each position sees every input pair for every operation. A fault confined to one position or one table entry is therefore caught within the first full pass of that operation.

// File: rtl/ttl_pkg.sv
package ttl_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_IS_NEG  = 4'd0,
        OP_IS_ZERO = 4'd1,
        OP_IS_POS  = 4'd2,
        OP_INC     = 4'd3,
        OP_DEC     = 4'd4,
        OP_EQ      = 4'd5,
        OP_SUM     = 4'd6,
        OP_CONS    = 4'd7,
        OP_ANY     = 4'd8,
        OP_NMIN    = 4'd9,
        OP_NMAX    = 4'd10
    } op_e;

    localparam logic [OP_W-1:0] OP_LAST = 4'd10;

    localparam logic [1:0] T_ZERO = 2'b00;
    localparam logic [1:0] T_POS  = 2'b01;
    localparam logic [1:0] T_NEG  = 2'b10;

    // Trit to signed value; the illegal code is read as zero.
    function automatic logic signed [2:0] trit_val(input logic [1:0] t);
        case (t)
            T_POS:   trit_val = 3'sd1;
            T_NEG:   trit_val = -3'sd1;
            default: trit_val = 3'sd0;
        endcase
    endfunction

    // Signed value in -1..1 to trit code.
    function automatic logic [1:0] val_trit(input logic signed [2:0] v);
        if (v > 0)      val_trit = T_POS;
        else if (v < 0) val_trit = T_NEG;
        else            val_trit = T_ZERO;
    endfunction
endpackage

// File: rtl/ttl_code_check.sv
module ttl_code_check
    import ttl_pkg::*;
#(
    parameter int N_TRITS = 4
) (
    input  logic [OP_W-1:0]      op_i,
    input  logic [2*N_TRITS-1:0] a_i,
    input  logic [2*N_TRITS-1:0] b_i,
    output logic                 bad_trit_o,
    output logic                 bad_op_o
);
    always_comb begin
        bad_trit_o = 1'b0;
        for (int k = 0; k < N_TRITS; k++) begin
            if (a_i[2*k +: 2] == 2'b11 || b_i[2*k +: 2] == 2'b11)
                bad_trit_o = 1'b1;
        end
        bad_op_o = (op_i > OP_LAST);
    end
endmodule

// File: rtl/ttl_trit_cell.sv
module ttl_trit_cell
    import ttl_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic [1:0]      a_i,
    input  logic [1:0]      b_i,
    output logic [1:0]      y_o
);
    logic signed [2:0] av, bv, s, lo, hi, r;

    always_comb begin
        av = trit_val(a_i);
        bv = trit_val(b_i);
        s  = av + bv;
        lo = (av < bv) ? av : bv;
        hi = (av < bv) ? bv : av;
        r  = 3'sd0;
        case (op_i)
            OP_IS_NEG:  r = (av == -3'sd1) ? 3'sd1 : -3'sd1;
            OP_IS_ZERO: r = (av ==  3'sd0) ? 3'sd1 : -3'sd1;
            OP_IS_POS:  r = (av ==  3'sd1) ? 3'sd1 : -3'sd1;
            OP_INC:     r = (av ==  3'sd1) ? -3'sd1 : av + 3'sd1;
            OP_DEC:     r = (av == -3'sd1) ?  3'sd1 : av - 3'sd1;
            OP_EQ:      r = (av == bv) ? 3'sd1 : -3'sd1;
            OP_SUM: begin
                if (s > 3'sd1)       r = -3'sd1;
                else if (s < -3'sd1) r = 3'sd1;
                else                 r = s;
            end
            OP_CONS:    r = (av == bv) ? av : 3'sd0;
            OP_ANY:     r = s;
            OP_NMIN:    r = -lo;
            OP_NMAX:    r = -hi;
            default:    r = 3'sd0;
        endcase
        y_o = val_trit(r);
    end
endmodule

// File: rtl/ttl_unit.sv
module ttl_unit
    import ttl_pkg::*;
#(
    parameter int N_TRITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           op_i,
    input  logic [2*N_TRITS-1:0] a_i,
    input  logic [2*N_TRITS-1:0] b_i,
    output logic [2*N_TRITS-1:0] res_o,
    output logic                 err_o
);
    localparam int W = 2 * N_TRITS;

    function automatic logic [W-1:0] plus_mask();
        logic [W-1:0] m;
        m = '0;
        for (int k = 0; k < N_TRITS; k++) m[2*k] = 1'b1;
        return m;
    endfunction

    localparam logic [W-1:0] LO_MASK = plus_mask();

    typedef struct packed {
        logic [W-1:0] res;
        logic         err;
    } out_t;

    out_t         out_d, out_q;
    logic [W-1:0] cell_y;
    logic         bad_trit, bad_op;

    for (genvar k = 0; k < N_TRITS; k++) begin : g_cell
        ttl_trit_cell u_cell (
            .op_i (op_i),
            .a_i  (a_i[2*k +: 2]),
            .b_i  (b_i[2*k +: 2]),
            .y_o  (cell_y[2*k +: 2])
        );
    end

    ttl_code_check #(.N_TRITS(N_TRITS)) u_check (
        .op_i       (op_i),
        .a_i        (a_i),
        .b_i        (b_i),
        .bad_trit_o (bad_trit),
        .bad_op_o   (bad_op)
    );

    always_comb begin
        out_d     = out_q;
        out_d.res = bad_op ? '0 : cell_y;
        out_d.err = bad_trit | bad_op;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_o = out_q.res;
    assign err_o = out_q.err;

    logic is_test;
    assign is_test = (op_i == OP_IS_NEG) || (op_i == OP_IS_ZERO) ||
                     (op_i == OP_IS_POS) || (op_i == OP_EQ);

    AST_ERR_ON_BAD_TRIT: assert property (@(posedge clk) disable iff (!rst_n)
        bad_trit |=> err_o) else $error("illegal trit not flagged"); // R10

    AST_NO_ILLEGAL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ((res_o & (res_o >> 1) & LO_MASK) == '0)) else $error("illegal trit on result"); // R10

    AST_BADOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |=> (res_o == '0 && err_o)) else $error("illegal op not cleared"); // R11

    AST_TEST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        is_test |=> (((res_o | (res_o >> 1)) & LO_MASK) == LO_MASK)) else $error("test op gave zero trit"); // R2
endmodule

// File: tb/ttl_unit_bench.sv
`timescale 1ns/1ps
module ttl_unit_bench;
    localparam int N  = 4;
    localparam int W  = 2 * N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   op_i = '0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic [W-1:0] res_o;
    logic         err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ttl_unit #(.N_TRITS(N)) u_ttl_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .res_o(res_o), .err_o(err_o)
    );

    function automatic int dec(input logic [1:0] t);
        if (t == 2'b01) return 1;
        if (t == 2'b10) return -1;
        return 0;
    endfunction

    function automatic logic [1:0] enc(input int v);
        if (v == 1)  return 2'b01;
        if (v == -1) return 2'b10;
        return 2'b00;
    endfunction

    function automatic int neg(input int v);
        return 0 - v;
    endfunction

    function automatic logic [1:0] ref_trit(input int op, input logic [1:0] ta, input logic [1:0] tb);
        int x, y, m;
        x = dec(ta);
        y = dec(tb);
        case (op)
            0:  return enc(x == -1 ? 1 : -1);
            1:  return enc(x == 0 ? 1 : -1);
            2:  return enc(x == 1 ? 1 : -1);
            3:  return enc(x == -1 ? 0 : (x == 0 ? 1 : -1));
            4:  return enc(x == 1 ? 0 : (x == 0 ? -1 : 1));
            5:  return enc(x == y ? 1 : -1);
            6: begin
                m = (((x + y) % 3) + 3) % 3;
                return enc(m == 2 ? -1 : m);
            end
            7:  return (x == y) ? enc(x) : 2'b00;
            8: begin
                if (x == 0) return enc(y);
                if (y == 0) return enc(x);
                return (x == y) ? enc(x) : 2'b00;
            end
            9:  return enc(neg(x < y ? x : y));
            10: return enc(neg(x > y ? x : y));
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [W-1:0] ref_vec(input int op, input logic [W-1:0] va, input logic [W-1:0] vb);
        logic [W-1:0] r;
        for (int k = 0; k < N; k++) r[2*k +: 2] = ref_trit(op, va[2*k +: 2], vb[2*k +: 2]);
        return r;
    endfunction

    function automatic logic [W-1:0] pat(input int seed, input int step);
        logic [W-1:0] v;
        for (int k = 0; k < N; k++) v[2*k +: 2] = enc(((seed + step * k) % 3) - 1);
        return v;
    endfunction

    task automatic check(input string req, input logic [W-1:0] exp_r, input logic exp_e);
        n_cmp++;
        if (res_o !== exp_r || err_o !== exp_e) begin
            n_bad++;
            $display("FAIL %s: res=%h err=%b expected res=%h err=%b", req, res_o, err_o, exp_r, exp_e);
        end
    endtask

    task automatic apply(input int op, input logic [W-1:0] va, input logic [W-1:0] vb);
        @(negedge clk);
        op_i = op[3:0];
        a_i  = va;
        b_i  = vb;
        @(negedge clk);
    endtask

    task automatic run_op(input string req, input int op);
        for (int ia = 0; ia < 3; ia++) begin
            for (int ib = 0; ib < 3; ib++) begin
                apply(op, pat(ia, 1), pat(ib, 2));
                check(req, ref_vec(op, pat(ia, 1), pat(ib, 2)), 1'b0);
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        op_i = 4'd2; a_i = pat(0, 1); b_i = pat(1, 1);
        @(negedge clk);
        check("R1 in reset", '0, 1'b0);
        rst_n = 1'b1;
        op_i = '0; a_i = '0; b_i = '0;
        @(negedge clk);
        check("R1 latency", {N{2'b10}}, 1'b0);
    endtask

    task automatic t_match();
        run_op("R2 is-neg", 0);
        run_op("R2 is-zero", 1);
        run_op("R2 is-pos", 2);
        apply(0, {N{2'b10}}, '0);
        check("R2 all neg", {N{2'b01}}, 1'b0);
    endtask

    task automatic t_incdec();
        run_op("R4 inc", 3);
        apply(3, {N{2'b01}}, '0);
        check("R4 inc wrap", {N{2'b10}}, 1'b0);
        run_op("R5 dec", 4);
        apply(4, {N{2'b10}}, '0);
        check("R5 dec wrap", {N{2'b01}}, 1'b0);
    endtask

    task automatic t_binary();
        run_op("R3 eq", 5);
        run_op("R6 sum", 6);
        apply(6, {N{2'b01}}, {N{2'b01}});
        check("R6 sum ++", {N{2'b10}}, 1'b0);
        run_op("R7 consensus", 7);
        run_op("R8 any", 8);
        apply(8, {N{2'b01}}, {N{2'b10}});
        check("R8 any disagree", '0, 1'b0);
        run_op("R9 nmin", 9);
        run_op("R9 nmax", 10);
    endtask

    task automatic t_bad_trit();
        logic [W-1:0] va;
        va = pat(0, 1);
        va[1:0] = 2'b11;
        apply(3, va, '0);
        check("R10 bad trit inc", ref_vec(3, va, '0), 1'b1);
        apply(5, '0, {N{2'b11}});
        check("R10 bad trit eq", {N{2'b01}}, 1'b1);
        apply(6, pat(1, 1), pat(2, 2));
        check("R10 flag clears", ref_vec(6, pat(1, 1), pat(2, 2)), 1'b0);
    endtask

    task automatic t_bad_op();
        apply(11, {N{2'b01}}, {N{2'b01}});
        check("R11 op 11", '0, 1'b1);
        apply(15, pat(2, 1), pat(0, 2));
        check("R11 op 15", '0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_match();
        t_incdec();
        t_binary();
        t_bad_trit();
        t_bad_op();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule